// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a reconfigurable two-level logic array. Its 36 logic inputs go to a programmable AND plane in both true and inverted form. Each of the 16 outputs ORs together five product terms that belong to it alone. It can also OR in any subset of a pool of 32 product terms, and every output draws on that same pool. Which pool terms reach which output is set by a programmable OR plane. Six further terms act as control signals, and each of them is configured as either an AND or an OR of the literals it selects.

The logic path from `x_in` to the outputs is purely combinational. The configuration sits in two register banks. Software-side logic writes a staging bank one item at a time through an address/data port: one product term per write, or one OR-plane row, or the control-term mode word. A single commit strobe then copies the whole staging bank into the live bank. The array therefore never evaluates a half-written configuration.

Address map (`cfg_addr`): 0..79 are the private terms, with output j's term k at j*5+k. 80..111 are pool terms 0..31. 112..117 are control terms 0..5. 118..133 are OR-plane rows for outputs 0..15, where data bit p routes pool term p. 134 is the mode word, where data bit c set makes control term c an OR. Any other address is unused.

Top module: `sop_array`

## Requirements
- R1: While `rst_n` is low at a clock edge, both banks clear, so after reset `mc_out` and `ct_out` are all zero for any `x_in`.
- R2: A term word enables input i's true literal with bit 2i and its inverted literal with bit 2i+1. An AND-type term is 1 exactly when every enabled literal is 1, so a term that enables both literals of one input never fires.
- R3: A term with no enabled literals evaluates to 0, and an output whose private terms and routed pool terms are all empty stays 0.
- R4: The private term written at address j*5+k drives only output j.
- R5: Pool term p (address 80+p) reaches output j exactly when bit p of OR-plane row j (address 118+j) is set, and one pool term may feed several outputs.
- R6: A single output ORs all 37 of its sources: five private terms plus all 32 pool terms.
- R7: Control term c (address 112+c) is an AND of its enabled literals when bit c of the mode word (address 134) is 0, and an OR of them when that bit is 1.
- R8: An OR-type control term with no enabled literals evaluates to 0.
- R9: Writes change only the staging bank. Outputs keep following the old configuration until the clock edge that samples `cfg_commit` high, and from that edge on they follow the staged one.
- R10: Writes to unused addresses (135 and above) change nothing, even after a commit.
- R11: A change on `x_in` reaches `mc_out` and `ct_out` within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the staging bank |
| cfg_addr | input | 8 | Configuration item address |
| cfg_data | input | 72 | Term literal mask, OR-plane row, or mode word |
| cfg_commit | input | 1 | Copy staging bank to live bank |
| x_in | input | 36 | Logic inputs |
| mc_out | output | 16 | Per-output sums |
| ct_out | output | 6 | Control-term results |

## Verification
Evaluation results are due in the same cycle as the input change. The bench changes `x_in` away from any clock edge and samples one nanosecond later, with no edge in between. Configuration results are due at the first rising edge that sees the commit strobe. The bench raises `cfg_commit` on a falling edge and checks one nanosecond later that the outputs still show the old setup. It then checks the new setup at the next falling edge. Staged writes that are never committed are checked at the outputs, where they must have no effect.

// File: rtl/sop_pkg.sv
// Package sop_pkg
// Shared default dimensions for the sum-of-products array.
// Assumes every configuration word is at least as wide as a pool row.
package sop_pkg;
    localparam int DEF_N_IN   = 36;
    localparam int DEF_N_OUT  = 16;
    localparam int DEF_N_PRIV = 5;
    localparam int DEF_N_POOL = 32;
    localparam int DEF_N_CT   = 6;
endpackage

// File: rtl/sop_cfg_store.sv
// Module sop_cfg_store
// Holds a staging bank written one item per cycle and a live bank that
// takes the whole staging bank on a commit strobe.
// Assumes a write and a commit in the same cycle commit the older staging
// content; unused addresses are ignored.
module sop_cfg_store #(
    parameter int N_TERM = 118,
    parameter int N_OUT  = 16,
    parameter int N_POOL = 32,
    parameter int N_CT   = 6,
    parameter int LIT_W  = 72,
    parameter int ADDR_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [ADDR_W-1:0]                cfg_addr,
    input  logic [LIT_W-1:0]                 cfg_data,
    input  logic                             cfg_commit,
    output logic [N_TERM-1:0][LIT_W-1:0]     term_act,
    output logic [N_OUT-1:0][N_POOL-1:0]     or_act,
    output logic [N_CT-1:0]                  mode_act
);
    localparam int ROW_BASE  = N_TERM;
    localparam int MODE_ADDR = N_TERM + N_OUT;

    logic [N_TERM-1:0][LIT_W-1:0] term_stg;
    logic [N_OUT-1:0][N_POOL-1:0] or_stg;
    logic [N_CT-1:0]              mode_stg;

    // Stage one term word, OR-plane row or mode word per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_stg <= '0;
            or_stg   <= '0;
            mode_stg <= '0;
        end else if (cfg_we) begin
            for (int t = 0; t < N_TERM; t++) begin
                if (cfg_addr == ADDR_W'(t)) term_stg[t] <= cfg_data;
            end
            for (int j = 0; j < N_OUT; j++) begin
                if (cfg_addr == ADDR_W'(ROW_BASE + j)) or_stg[j] <= cfg_data[N_POOL-1:0];
            end
            if (cfg_addr == ADDR_W'(MODE_ADDR)) mode_stg <= cfg_data[N_CT-1:0];
        end
    end

    // Transfer the whole staging bank into the live bank on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_act <= '0;
            or_act   <= '0;
            mode_act <= '0;
        end else if (cfg_commit) begin
            term_act <= term_stg;
            or_act   <= or_stg;
            mode_act <= mode_stg;
        end
    end
endmodule

// File: rtl/sop_term.sv
// Module sop_term
// Evaluates one term over a literal vector: AND of enabled literals, or
// OR of them when sum_mode is set.
// Assumes an empty mask yields 0 in both modes.
module sop_term #(
    parameter int LIT_W = 72
) (
    input  logic [LIT_W-1:0] lits,
    input  logic [LIT_W-1:0] mask,
    input  logic             sum_mode,
    output logic             hit
);
    logic any_en;
    logic any_low;
    logic any_high;

    // Reduce the masked literals and pick the product or sum result.
    always_comb begin
        any_en   = |mask;
        any_low  = |(mask & ~lits);
        any_high = |(mask & lits);
        hit      = sum_mode ? any_high : (any_en & ~any_low);
    end
endmodule

// File: rtl/sop_or_plane.sv
// Module sop_or_plane
// Combines each output's private terms through a fixed OR with the pool
// terms its routing row selects.
// Assumes private terms are grouped per output, N_PRIV apiece.
module sop_or_plane #(
    parameter int N_OUT  = 16,
    parameter int N_PRIV = 5,
    parameter int N_POOL = 32
) (
    input  logic [N_OUT*N_PRIV-1:0]      priv_hit,
    input  logic [N_POOL-1:0]            pool_hit,
    input  logic [N_OUT-1:0][N_POOL-1:0] or_act,
    output logic [N_OUT-1:0]             mc_out
);
    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        // One output sum: private group plus routed pool terms.
        assign mc_out[j] = (|priv_hit[j*N_PRIV +: N_PRIV]) | (|(pool_hit & or_act[j]));
    end
endmodule

// File: rtl/sop_array.sv
// Module sop_array
// Top of the sum-of-products array: configuration banks, AND plane of
// private, pool and control terms, and the output OR plane.
// Assumes x_in to outputs is combinational; only configuration is clocked.
module sop_array
    import sop_pkg::*;
#(
    parameter  int N_IN   = DEF_N_IN,
    parameter  int N_OUT  = DEF_N_OUT,
    parameter  int N_PRIV = DEF_N_PRIV,
    parameter  int N_POOL = DEF_N_POOL,
    parameter  int N_CT   = DEF_N_CT,
    localparam int LIT_W     = 2 * N_IN,
    localparam int POOL_BASE = N_OUT * N_PRIV,
    localparam int CT_BASE   = POOL_BASE + N_POOL,
    localparam int N_TERM    = CT_BASE + N_CT,
    localparam int N_ADDR    = N_TERM + N_OUT + 1,
    localparam int ADDR_W    = $clog2(N_ADDR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LIT_W-1:0]  cfg_data,
    input  logic              cfg_commit,
    input  logic [N_IN-1:0]   x_in,
    output logic [N_OUT-1:0]  mc_out,
    output logic [N_CT-1:0]   ct_out
);
    logic [N_TERM-1:0][LIT_W-1:0] term_act;
    logic [N_OUT-1:0][N_POOL-1:0] or_act;
    logic [N_CT-1:0]              mode_act;
    logic [LIT_W-1:0]             lits;
    logic [N_TERM-1:0]            term_hit;

    sop_cfg_store #(
        .N_TERM(N_TERM), .N_OUT(N_OUT), .N_POOL(N_POOL),
        .N_CT(N_CT), .LIT_W(LIT_W), .ADDR_W(ADDR_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .cfg_commit(cfg_commit),
        .term_act(term_act), .or_act(or_act), .mode_act(mode_act)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        // True literal on even bit, inverted literal on odd bit.
        assign lits[2*i]   = x_in[i];
        assign lits[2*i+1] = ~x_in[i];
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        if (t >= CT_BASE) begin : g_ctl
            sop_term #(.LIT_W(LIT_W)) u_term (
                .lits(lits), .mask(term_act[t]),
                .sum_mode(mode_act[t-CT_BASE]), .hit(term_hit[t])
            );
        end else begin : g_prod
            sop_term #(.LIT_W(LIT_W)) u_term (
                .lits(lits), .mask(term_act[t]),
                .sum_mode(1'b0), .hit(term_hit[t])
            );
        end
    end

    sop_or_plane #(.N_OUT(N_OUT), .N_PRIV(N_PRIV), .N_POOL(N_POOL)) u_or (
        .priv_hit(term_hit[POOL_BASE-1:0]),
        .pool_hit(term_hit[POOL_BASE +: N_POOL]),
        .or_act(or_act),
        .mc_out(mc_out)
    );

    assign ct_out = term_hit[CT_BASE +: N_CT];
endmodule

// File: rtl/sop_chk.sv
// Module sop_chk
// Property checker bound into sop_array; observes ports and live bank.
// Assumes inputs change away from rising clock edges.
module sop_chk #(
    parameter int N_IN   = 36,
    parameter int N_OUT  = 16,
    parameter int N_PRIV = 5,
    parameter int N_POOL = 32,
    parameter int N_CT   = 6,
    parameter int LIT_W  = 72,
    parameter int N_TERM = 118
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_commit,
    input logic [N_IN-1:0]              x_in,
    input logic [N_OUT-1:0]             mc_out,
    input logic [N_CT-1:0]              ct_out,
    input logic [N_TERM-1:0][LIT_W-1:0] term_act,
    input logic [N_OUT-1:0][N_POOL-1:0] or_act,
    input logic [N_CT-1:0]              mode_act
);
    localparam int POOL_BASE = N_OUT * N_PRIV;
    localparam int CT_BASE   = POOL_BASE + N_POOL;

    // R1: first cycle out of reset shows a cleared array.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mc_out == '0 && ct_out == '0));

    // R9: live bank moves only on a commit.
    a_r9_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_commit |=> ($stable(term_act) && $stable(or_act) && $stable(mode_act)));

    // R11: without commit, outputs move only when inputs move.
    a_r11_comb_only: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_commit |=> (!$stable(x_in) || ($stable(mc_out) && $stable(ct_out))));

    // R3, R8: empty terms never drive an output.
    always @(posedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < N_CT; c++) begin
                if (term_act[CT_BASE+c] == '0)
                    a_r8_empty_ct: assert (ct_out[c] == 1'b0);
            end
            for (int j = 0; j < N_OUT; j++) begin
                logic live;
                live = 1'b0;
                for (int k = 0; k < N_PRIV; k++)
                    if (term_act[j*N_PRIV+k] != '0) live = 1'b1;
                for (int p = 0; p < N_POOL; p++)
                    if (or_act[j][p] && term_act[POOL_BASE+p] != '0) live = 1'b1;
                if (!live)
                    a_r3_empty_out: assert (mc_out[j] == 1'b0);
            end
        end
    end
endmodule

bind sop_array sop_chk #(
    .N_IN(N_IN), .N_OUT(N_OUT), .N_PRIV(N_PRIV), .N_POOL(N_POOL),
    .N_CT(N_CT), .LIT_W(LIT_W), .N_TERM(N_TERM)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_commit(cfg_commit), .x_in(x_in),
    .mc_out(mc_out), .ct_out(ct_out), .term_act(term_act),
    .or_act(or_act), .mode_act(mode_act)
);

// File: tb/tb_sop_array.sv
// Directed bench for sop_array: one task per scenario.
module tb_sop_array;
    localparam int CLK_PERIOD = 10;
    localparam int LIT_W = 72;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [7:0]        cfg_addr = '0;
    logic [LIT_W-1:0]  cfg_data = '0;
    logic              cfg_commit = 1'b0;
    logic [35:0]       x_in = '0;
    logic [15:0]       mc_out;
    logic [5:0]        ct_out;
    int n_run = 0;
    int n_fail = 0;

    sop_array dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .cfg_commit(cfg_commit), .x_in(x_in),
        .mc_out(mc_out), .ct_out(ct_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [LIT_W-1:0] lit(input int i, input bit inv);
        logic [LIT_W-1:0] w;
        w = '0;
        w[2*i + (inv ? 1 : 0)] = 1'b1;
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [LIT_W-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'(addr); cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk);
        cfg_commit = 1'b1;
        @(negedge clk);
        cfg_commit = 1'b0;
    endtask

    task automatic drive_x(input logic [35:0] v);
        x_in = v;
        #1;
    endtask

    task automatic t_reset();
        x_in = '1;
        repeat (3) @(negedge clk);
        check("R1 mc_out in reset", 32'(mc_out), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        drive_x(36'h5_A5A5_A5A5);
        check("R1 mc_out after reset", 32'(mc_out), 32'h0);
        check("R1 ct_out after reset", 32'(ct_out), 32'h0);
    endtask

    task automatic t_product();
        wr(0, lit(0, 0) | lit(35, 1));
        drive_x(36'h0_0000_0001);
        check("R9 staged not live", 32'(mc_out[0]), 32'h0);
        @(negedge clk);
        cfg_commit = 1'b1;
        #1;
        check("R9 before commit edge", 32'(mc_out[0]), 32'h0);
        @(negedge clk);
        cfg_commit = 1'b0;
        check("R9 after commit edge", 32'(mc_out[0]), 32'h1);
        drive_x(36'h8_0000_0001);
        check("R2 inverted literal low", 32'(mc_out[0]), 32'h0);
        drive_x(36'h0_0000_0000);
        check("R2 true literal low", 32'(mc_out[0]), 32'h0);
    endtask

    task automatic t_empty();
        drive_x('1);
        check("R3 empty out all-ones", 32'(mc_out[1]), 32'h0);
        drive_x('0);
        check("R3 empty out all-zeros", 32'(mc_out[1]), 32'h0);
        wr(5, lit(3, 0) | lit(3, 1));
        commit();
        drive_x('1);
        check("R2 contradictory term x=1", 32'(mc_out[1]), 32'h0);
        drive_x('0);
        check("R2 contradictory term x=0", 32'(mc_out[1]), 32'h0);
    endtask

    task automatic t_private();
        wr(3*5+4, lit(5, 0));
        commit();
        drive_x(36'h0_0000_0020);
        check("R4 private term output only", 32'(mc_out), 32'h0008);
    endtask

    task automatic t_pool();
        wr(87, lit(10, 1));
        wr(118+2, 72'(32'h0000_0080));
        wr(118+15, 72'(32'h0000_0080));
        commit();
        drive_x('1);
        check("R5 pool term idle", 32'(mc_out), 32'h0008);
        @(negedge clk);
        #2;
        drive_x(36'hF_FFFF_FBFF);
        check("R5 pool term shared", 32'(mc_out), 32'h800C);
        check("R11 same-cycle response", 32'(mc_out[15]), 32'h1);
    endtask

    task automatic t_wide();
        for (int k = 0; k < 5; k++) wr(9*5+k, lit(k, 0));
        for (int p = 0; p < 32; p++) wr(80+p, lit(p+4, 0));
        wr(118+9, 72'(32'hFFFF_FFFF));
        commit();
        drive_x('0);
        check("R6 no source", 32'(mc_out[9]), 32'h0);
        for (int i = 0; i < 36; i++) begin
            drive_x(36'(1) << i);
            check($sformatf("R6 source on input %0d", i), 32'(mc_out[9]), 32'h1);
        end
    endtask

    task automatic t_control();
        wr(112, lit(1, 0) | lit(2, 0));
        wr(113, lit(1, 0) | lit(2, 0));
        wr(134, 72'(6'b000110));
        commit();
        for (int v = 0; v < 4; v++) begin
            logic a, b;
            a = v[0]; b = v[1];
            drive_x(36'(v) << 1);
            check($sformatf("R7 product/sum v=%0d", v), 32'(ct_out[1:0]),
                  32'({a | b, a & b}));
            check($sformatf("R8 empty control v=%0d", v), 32'(ct_out[5:2]), 32'h0);
        end
    endtask

    task automatic t_hold();
        wr(112, lit(20, 0));
        wr(134, 72'(0));
        drive_x(36'h0_0000_0006);
        check("R9 uncommitted writes", 32'(ct_out[1:0]), 32'h3);
        commit();
        check("R9 committed writes", 32'(ct_out[1:0]), 32'h2);
    endtask

    task automatic t_unused();
        logic [15:0] m0, m1;
        logic [5:0]  c0, c1;
        drive_x(36'h0_0000_0006);
        m0 = mc_out; c0 = ct_out;
        drive_x(36'hF_FFFF_FBFF);
        m1 = mc_out; c1 = ct_out;
        wr(135, '1);
        wr(255, '1);
        commit();
        drive_x(36'h0_0000_0006);
        check("R10 unused addr mc A", 32'(mc_out), 32'(m0));
        check("R10 unused addr ct A", 32'(ct_out), 32'(c0));
        drive_x(36'hF_FFFF_FBFF);
        check("R10 unused addr mc B", 32'(mc_out), 32'(m1));
        check("R10 unused addr ct B", 32'(ct_out), 32'(c1));
    endtask

    initial begin
        t_reset();
        t_product();
        t_empty();
        t_private();
        t_pool();
        t_wide();
        t_control();
        t_hold();
        t_unused();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule